// File: doc/BRIEF.md
# NMI source status and control port

This block is an 8-bit status and control port that gathers two error sources into one non-maskable interrupt request. One source is a single-cycle system-error pulse from a bus agent. The other is a channel-check level that comes from a serial interrupt decoder. Each source has an active-low enable bit. While a source is enabled, its event is captured in a sticky status bit. That bit stays set after the source goes away.

Software reads the port to find the cause of an NMI. To clear a captured cause, software writes the matching enable bit to 1 and then back to 0. The same port also reports two other values: the live level of an external interval-timer channel, and a refresh toggle that flips at a fixed period. The block derives that period from its own clock. The NMI request output is the OR of the two status bits, suppressed while a global mask input is high. Address decode happens upstream, so a write strobe here always targets this register.

Top module: `nmi_status_port`

## Requirements
- R1: After a synchronous reset with `tmr_out` low, `rd_data` reads 8'h00 and `nmi_req` is 0.
- R2: A one-cycle `serr_pulse` while bit 2 (system-error disable) is 0 sets bit 7 at the next clock edge. Bit 7 stays set after the pulse ends for as long as bit 2 remains 0.
- R3: `chk_level` high while bit 3 (channel-check disable) is 0 sets bit 6 at the next clock edge. Bit 6 stays set after the level drops for as long as bit 3 remains 0.
- R4: While bit 2 is 1, bit 7 is forced clear from the clock edge after bit 2 became 1, and `serr_pulse` has no effect. Writing bit 2 to 1 and then to 0 leaves bit 7 clear.
- R5: While bit 3 is 1, bit 6 is forced clear from the clock edge after bit 3 became 1, and `chk_level` has no effect. Writing bit 3 to 1 and then to 0 leaves bit 6 clear.
- R6: Bit 5 equals the current level of `tmr_out`, with no clock delay.
- R7: Bit 4 starts at 0 after reset and inverts once every `CLK_FREQ_HZ*REFRESH_NS/1e9` clock cycles.
- R8: A write takes `wr_data[3:0]` into bits 3..0. `wr_data[7:4]` is ignored, and status bits 7 and 6 are not changed by the written value.
- R9: Bits 1 and 0 are plain storage. They read back the last value written to them.
- R10: `nmi_req` is 1 exactly when bit 7 or bit 6 is set and `nmi_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for this register (already decoded upstream) |
| wr_data | input | 8 | Write data; bits 7..4 ignored |
| rd_data | output | 8 | Current register value |
| serr_pulse | input | 1 | One-cycle system-error pulse |
| chk_level | input | 1 | Channel-check level from the serial interrupt decoder |
| tmr_out | input | 1 | Live output of the external timer channel |
| nmi_mask | input | 1 | Global NMI mask; 1 suppresses `nmi_req` |
| nmi_req | output | 1 | NMI request |

## Verification
The results arrive at three different latencies:
- A write, a source event, or a change of the refresh toggle shows up in `rd_data` right after the next rising edge.
- A disable bit clears its status bit one edge later than that, because the clear uses the registered enable.
- The `tmr_out` mirror and the `nmi_req` gating with `nmi_mask` follow with no clock delay.

The bench drives stimulus and samples outputs one time unit after the rising edge. For the clear sequence it checks both the edge where the status is still held and the edge where it drops. The refresh period is measured by counting sampled cycles between two consecutive flips.

// File: rtl/nmi_pkg.sv
// Package: shared widths and bit positions of the NMI status/control register.
// Assumes: register layout is fixed; bit positions are behaviour the software decodes.
package nmi_pkg;
    localparam int REG_W      = 8;
    localparam int NUM_SRC    = 2;    // index 0: system error, index 1: channel check
    localparam int SRC_SERR   = 0;
    localparam int SRC_CHK    = 1;
    localparam int BIT_SERR_STS = 7;
    localparam int BIT_CHK_STS  = 6;
    localparam int BIT_TMR      = 5;
    localparam int BIT_REFRESH  = 4;
    localparam int BIT_CHK_DIS  = 3;
    localparam int BIT_SERR_DIS = 2;
    localparam int SPARE_W      = 2;  // bits 1..0, plain storage
endpackage

// File: rtl/nmi_refresh_div.sv
// Module: free-running divider producing a refresh toggle.
// Assumes: DIV >= 2; toggle starts at 0 after reset and inverts every DIV cycles.
module nmi_refresh_div #(
    parameter int DIV = 1500
) (
    input  logic clk,
    input  logic rst_n,
    output logic tgl
);
    localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Count cycles and invert the toggle at the end of each interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl   <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
            tgl   <= ~tgl;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/nmi_src_latch.sv
// Module: sticky status flag for one NMI source with active-low enable.
// Assumes: dis is the registered disable bit; clear has priority over set.
module nmi_src_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic dis,
    output logic sts
);
    // Hold the flag once set; disable forces and keeps it clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   sts <= 1'b0;
        else if (dis) sts <= 1'b0;
        else          sts <= sts | src;
    end
endmodule

// File: rtl/nmi_status_port.sv
// Module: NMI status and control register with NMI request generation.
// Assumes: wr_en is already address-decoded; inputs are synchronous to clk;
//          tmr_out is passed straight to the read path.
module nmi_status_port #(
    parameter int CLK_FREQ_HZ = 100_000_000,
    parameter int REFRESH_NS  = 15_000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [nmi_pkg::REG_W-1:0] wr_data,
    output logic [nmi_pkg::REG_W-1:0] rd_data,
    input  logic                     serr_pulse,
    input  logic                     chk_level,
    input  logic                     tmr_out,
    input  logic                     nmi_mask,
    output logic                     nmi_req
);
    import nmi_pkg::*;

    localparam longint DIV_L = (longint'(CLK_FREQ_HZ) * longint'(REFRESH_NS)) / 64'd1_000_000_000;
    localparam int     DIV   = (DIV_L < 2) ? 2 : int'(DIV_L);

    logic [NUM_SRC-1:0] dis_q;
    logic [NUM_SRC-1:0] src_in;
    logic [NUM_SRC-1:0] sts;
    logic [SPARE_W-1:0] spare_q;
    logic               refresh_tgl;

    // Capture control bits 3..0 on a write; upper bits are ignored.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dis_q   <= '0;
            spare_q <= '0;
        end else if (wr_en) begin
            dis_q[SRC_SERR] <= wr_data[BIT_SERR_DIS];
            dis_q[SRC_CHK]  <= wr_data[BIT_CHK_DIS];
            spare_q         <= wr_data[SPARE_W-1:0];
        end
    end

    // Collect the source inputs in latch index order.
    always_comb begin
        src_in           = '0;
        src_in[SRC_SERR] = serr_pulse;
        src_in[SRC_CHK]  = chk_level;
    end

    // One sticky latch per source.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        nmi_src_latch u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (src_in[i]),
            .dis   (dis_q[i]),
            .sts   (sts[i])
        );
    end

    nmi_refresh_div #(.DIV(DIV)) u_refresh (
        .clk   (clk),
        .rst_n (rst_n),
        .tgl   (refresh_tgl)
    );

    // Assemble the read value in its fixed bit layout.
    always_comb begin
        rd_data               = '0;
        rd_data[BIT_SERR_STS] = sts[SRC_SERR];
        rd_data[BIT_CHK_STS]  = sts[SRC_CHK];
        rd_data[BIT_TMR]      = tmr_out;
        rd_data[BIT_REFRESH]  = refresh_tgl;
        rd_data[BIT_CHK_DIS]  = dis_q[SRC_CHK];
        rd_data[BIT_SERR_DIS] = dis_q[SRC_SERR];
        rd_data[SPARE_W-1:0]  = spare_q;
    end

    // Request an NMI for any latched cause unless globally masked.
    always_comb nmi_req = (|sts) & ~nmi_mask;
endmodule

// Checker: temporal properties of the port, observed at its pins.
module nmi_status_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       serr_pulse,
    input logic       chk_level,
    input logic       nmi_mask,
    input logic       nmi_req
);
    AST_SERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[2] && serr_pulse) |=> rd_data[7]);                 // R2
    AST_SERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !rd_data[2]) |=> rd_data[7]);                 // R2
    AST_CHK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_data[3] && chk_level) |=> rd_data[6]);                  // R3
    AST_SERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[2] |=> !rd_data[7]);                                 // R4
    AST_CHK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[3] |=> !rd_data[6]);                                 // R5
    AST_SPARE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[1:0] == $past(wr_data[1:0])));            // R9
    AST_NMI_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_mask |-> !nmi_req);                                      // R10
    AST_NMI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (rd_data[7] || rd_data[6]));                     // R10
endmodule

bind nmi_status_port nmi_status_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .serr_pulse (serr_pulse),
    .chk_level  (chk_level),
    .nmi_mask   (nmi_mask),
    .nmi_req    (nmi_req)
);

// File: tb/tb_nmi_status_port.sv
// Bench: directed scenarios for the NMI status/control port; one task each.
module tb_nmi_status_port;
    localparam int CLK_PERIOD = 10;
    localparam int FREQ       = 1_000_000;
    localparam int RNS        = 8_000;      // 8 cycles per refresh interval
    localparam int EXP_DIV    = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       serr_pulse = 1'b0;
    logic       chk_level = 1'b0;
    logic       tmr_out = 1'b0;
    logic       nmi_mask = 1'b0;
    logic       nmi_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nmi_status_port #(.CLK_FREQ_HZ(FREQ), .REFRESH_NS(RNS)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .serr_pulse(serr_pulse), .chk_level(chk_level),
        .tmr_out(tmr_out), .nmi_mask(nmi_mask), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance one edge; inputs change and outputs are sampled 1 unit later.
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 nmi_req", {7'd0, nmi_req}, 8'h00);
    endtask

    task automatic t_serr();
        serr_pulse = 1'b1; step(); serr_pulse = 1'b0;
        chk("R2 bit7 set", {7'd0, rd_data[7]}, 8'h01);
        step(); step(); step();
        chk("R2 bit7 sticky", {7'd0, rd_data[7]}, 8'h01);
        chk("R10 nmi_req from bit7", {7'd0, nmi_req}, 8'h01);
        nmi_mask = 1'b1; #1;
        chk("R10 masked", {7'd0, nmi_req}, 8'h00);
        nmi_mask = 1'b0; #1;
        wr(8'h04);
        chk("R4 bit7 held first edge", {7'd0, rd_data[7]}, 8'h01);
        step();
        chk("R4 bit7 cleared", {7'd0, rd_data[7]}, 8'h00);
        serr_pulse = 1'b1; step(); serr_pulse = 1'b0; step();
        chk("R4 pulse ignored when disabled", {7'd0, rd_data[7]}, 8'h00);
        wr(8'h00); step();
        chk("R4 stays clear after re-enable", {7'd0, rd_data[7]}, 8'h00);
        chk("R10 idle", {7'd0, nmi_req}, 8'h00);
    endtask

    task automatic t_chk();
        chk_level = 1'b1; step(); step(); chk_level = 1'b0;
        chk("R3 bit6 set", {7'd0, rd_data[6]}, 8'h01);
        step(); step();
        chk("R3 bit6 sticky", {7'd0, rd_data[6]}, 8'h01);
        chk("R10 nmi_req from bit6", {7'd0, nmi_req}, 8'h01);
        chk("R3 bit7 untouched", {7'd0, rd_data[7]}, 8'h00);
        wr(8'h08); step();
        chk("R5 bit6 cleared", {7'd0, rd_data[6]}, 8'h00);
        chk_level = 1'b1; step(); step();
        chk("R5 level ignored when disabled", {7'd0, rd_data[6]}, 8'h00);
        chk_level = 1'b0;
        wr(8'h00); step();
        chk("R5 stays clear after re-enable", {7'd0, rd_data[6]}, 8'h00);
    endtask

    task automatic t_tmr();
        tmr_out = 1'b1; #1;
        chk("R6 tmr high", {7'd0, rd_data[5]}, 8'h01);
        tmr_out = 1'b0; #1;
        chk("R6 tmr low", {7'd0, rd_data[5]}, 8'h00);
    endtask

    task automatic t_write_mask();
        wr(8'hF3);
        chk("R8 upper bits ignored", rd_data & 8'hEF, 8'h03);
        chk("R9 spare readback 11", {6'd0, rd_data[1:0]}, 8'h03);
        wr(8'h02);
        chk("R9 spare readback 10", {6'd0, rd_data[1:0]}, 8'h02);
        wr(8'h0C);
        chk("R8 ctrl bits written", rd_data & 8'h0F, 8'h0C);
        wr(8'h00);
    endtask

    task automatic t_refresh();
        logic prev;
        int   n;
        prev = rd_data[4];
        n = 0;
        while (rd_data[4] == prev && n < 100) begin step(); n++; end
        prev = rd_data[4];
        n = 0;
        while (rd_data[4] == prev && n < 100) begin step(); n++; end
        chk("R7 refresh interval", 8'(n), 8'(EXP_DIV));
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_tmr();
        t_serr();
        t_chk();
        t_write_mask();
        t_refresh();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule